// File: doc/BRIEF.md
# Double-Rate Burst Beat and Strobe Path

This block moves fixed-length bursts between a core-clock controller and a double-rate data pin group that is paired with a strobe. Everything runs in one core clock domain. Each double-rate pin is shown as two values per core clock: lane "a" is the first half of the clock period and lane "b" is the second half. On the transmit side, a burst word and its per-beat byte masks are accepted in one cycle. The block then drives a strobe preamble, strobe toggles carrying two beats per clock, and a strobe postamble.

On the receive side, a read command starts a latency counter. The first rising strobe edge must arrive no earlier than `RD_LAT` clocks after the command clock and no later than `RD_SLACK` clocks after that. Beats are taken on both strobe edges and assembled into a burst word, which is presented with a one-cycle done pulse. If the strobe arrives early, arrives late, or stops in the middle of a burst, the burst is discarded and an error pulse is raised instead.

Top module: `ddr_beat_strobe_path`

## Requirements
- R1: While reset is held and after it is released, all strobe, data, mask, busy, done and error outputs are 0, and `rx_word` is 0.
- R2: In the cycle after an accepted `tx_start`, the block drives a preamble: `tx_stb_oe`=1, `tx_stb_a`=0, `tx_stb_b`=0, `tx_dat_oe`=0, `tx_busy`=1.
- R3: For the next BL/2 cycles the strobe toggles with `tx_stb_a`=1 and `tx_stb_b`=0, and `tx_dat_oe`=1. In pair cycle k, `tx_dat_a` carries beat 2k and `tx_dat_b` carries beat 2k+1, where beat j is `tx_data[j*DW +: DW]`.
- R4: The mask lanes follow their beats. `tx_msk_a` is `tx_mask[2k*MW +: MW]` and `tx_msk_b` is `tx_mask[(2k+1)*MW +: MW]`, with MW = DW/8 and a 1 meaning that byte lane must not be written. Outside the pair cycles, data and mask lanes are 0.
- R5: After the last pair comes one postamble cycle (`tx_stb_oe`=1, both strobe lanes 0, `tx_dat_oe`=0). In the following cycle `tx_stb_oe` and `tx_busy` return to 0. A `tx_start` accepted while `tx_busy`=1 is ignored and changes neither the running burst nor what follows it.
- R6: If `rx_cmd` is sampled at edge E, a strobe pair (`rx_stb_a`=1, `rx_stb_b`=0, with `rx_stb_b` of the previous cycle 0) sampled at edge E+RD_LAT+d, 0 <= d <= RD_SLACK, starts capture. Pair k takes beat 2k from `rx_dat_a` and beat 2k+1 from `rx_dat_b`, on consecutive edges.
- R7: After the edge that samples the final pair, `rx_done` is 1 for exactly one cycle and `rx_word` holds beat j at `[j*DW +: DW]`. `rx_word` keeps this value until the next done pulse.
- R8: If no strobe rise has been sampled by edge E+RD_LAT+RD_SLACK, `rx_err` pulses after that edge. No done follows, and `rx_word` is unchanged.
- R9: A strobe rise sampled before edge E+RD_LAT is an error: `rx_err` pulses after that edge and the burst is discarded.
- R10: If a strobe pair is missing in any later pair cycle of a started burst, `rx_err` pulses after that edge and the burst is discarded.
- R11: `rx_busy` is 1 from the cycle after an accepted command until the done or error cycle. An `rx_cmd` sampled while `rx_busy`=1 is ignored and does not restart the latency count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_start | input | 1 | Start a transmit burst |
| tx_data | input | BL*DW | Burst beats, beat j at [j*DW +: DW] |
| tx_mask | input | BL*MW | Per-beat byte masks, 1 = do not write |
| tx_busy | output | 1 | Transmit burst in progress |
| tx_stb_oe | output | 1 | Strobe output enable |
| tx_stb_a | output | 1 | Strobe level, first half of clock |
| tx_stb_b | output | 1 | Strobe level, second half of clock |
| tx_dat_oe | output | 1 | Data and mask output enable |
| tx_dat_a | output | DW | Even beat |
| tx_dat_b | output | DW | Odd beat |
| tx_msk_a | output | MW | Mask of even beat |
| tx_msk_b | output | MW | Mask of odd beat |
| rx_cmd | input | 1 | Read command |
| rx_stb_a | input | 1 | Received strobe, first half |
| rx_stb_b | input | 1 | Received strobe, second half |
| rx_dat_a | input | DW | Beat taken at the rising strobe edge |
| rx_dat_b | input | DW | Beat taken at the falling strobe edge |
| rx_busy | output | 1 | Read burst pending |
| rx_done | output | 1 | One-cycle pulse with assembled word |
| rx_err | output | 1 | One-cycle pulse on discarded burst |
| rx_word | output | BL*DW | Assembled read burst |

## Verification
A wrong transmit phase register shows up in the very next cycle as a missing preamble, a shifted or repeated beat pair, a mask on the wrong beat, or a strobe released too early. For this reason every transmit cycle of every swept pattern is compared. A wrong latency counter or capture index on the receive side shows up at the done or error pulse: it comes one edge early or late, the wrong one of the two fires, or beats in `rx_word` are swapped. Every allowed arrival offset, plus the early, late and broken cases, is therefore checked edge by edge from the command.

// File: rtl/dbs_pkg.sv
`timescale 1ns/1ps
package dbs_pkg;
   typedef enum logic [1:0] {TX_IDLE, TX_PRE, TX_PAIR, TX_POST} tx_state_e;
   typedef enum logic [1:0] {RX_IDLE, RX_WAIT, RX_CAPT} rx_state_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/dbs_tx_path.sv
`timescale 1ns/1ps
module dbs_tx_path
   import dbs_pkg::*;
#(
   parameter int DW    = 8,
   parameter int BL    = 4,
   parameter int MW    = 1,
   parameter bit SHIFT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [BL*DW-1:0]   data,
   input  logic [BL*MW-1:0]   mask,
   output logic               busy,
   output logic               stb_oe,
   output logic               stb_a,
   output logic               stb_b,
   output logic               dat_oe,
   output logic [DW-1:0]      dat_a,
   output logic [DW-1:0]      dat_b,
   output logic [MW-1:0]      msk_a,
   output logic [MW-1:0]      msk_b
);
   localparam int NP = BL / 2;
   localparam int IW = idx_width(NP);

   tx_state_e      state;
   logic [IW-1:0]  idx;
   logic           accept;
   logic           in_pair;
   logic [DW-1:0]  beat_a, beat_b;
   logic [MW-1:0]  bm_a, bm_b;

   assign accept  = start && (state == TX_IDLE);
   assign in_pair = (state == TX_PAIR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= TX_IDLE;
         idx   <= '0;
      end else begin
         case (state)
            TX_IDLE: if (accept) begin
               state <= TX_PRE;
               idx   <= '0;
            end
            TX_PRE:  state <= TX_PAIR;
            TX_PAIR: begin
               if (idx == IW'(NP - 1)) state <= TX_POST;
               else                    idx   <= idx + 1'b1;
            end
            default: state <= TX_IDLE;
         endcase
      end
   end

   generate
      if (SHIFT) begin : g_shift
         logic [BL*DW-1:0] sh_d;
         logic [BL*MW-1:0] sh_m;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sh_d <= '0;
               sh_m <= '0;
            end else if (accept) begin
               sh_d <= data;
               sh_m <= mask;
            end else if (in_pair) begin
               sh_d <= sh_d >> (2 * DW);
               sh_m <= sh_m >> (2 * MW);
            end
         end
         assign beat_a = sh_d[0 +: DW];
         assign beat_b = sh_d[DW +: DW];
         assign bm_a   = sh_m[0 +: MW];
         assign bm_b   = sh_m[MW +: MW];
      end else begin : g_mux
         logic [BL*DW-1:0] hold_d;
         logic [BL*MW-1:0] hold_m;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hold_d <= '0;
               hold_m <= '0;
            end else if (accept) begin
               hold_d <= data;
               hold_m <= mask;
            end
         end
         assign beat_a = hold_d[int'(idx) * 2 * DW +: DW];
         assign beat_b = hold_d[int'(idx) * 2 * DW + DW +: DW];
         assign bm_a   = hold_m[int'(idx) * 2 * MW +: MW];
         assign bm_b   = hold_m[int'(idx) * 2 * MW + MW +: MW];
      end
   endgenerate

   assign busy   = (state != TX_IDLE);
   assign stb_oe = busy;
   assign stb_a  = in_pair;
   assign stb_b  = 1'b0;
   assign dat_oe = in_pair;
   assign dat_a  = in_pair ? beat_a : '0;
   assign dat_b  = in_pair ? beat_b : '0;
   assign msk_a  = in_pair ? bm_a   : '0;
   assign msk_b  = in_pair ? bm_b   : '0;
endmodule

// File: rtl/dbs_lat_timer.sv
`timescale 1ns/1ps
module dbs_lat_timer #(
   parameter int RD_LAT   = 2,
   parameter int RD_SLACK = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic run,
   output logic early,
   output logic expired
);
   localparam int LIM = RD_LAT + RD_SLACK;
   localparam int CW  = $clog2(LIM + 2);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                          cnt <= '0;
      else if (start)                      cnt <= CW'(1);
      else if (run && (cnt != CW'(LIM)))   cnt <= cnt + 1'b1;
   end

   assign early   = (cnt < CW'(RD_LAT));
   assign expired = (cnt == CW'(LIM));
endmodule

// File: rtl/dbs_rx_capture.sv
`timescale 1ns/1ps
module dbs_rx_capture
   import dbs_pkg::*;
#(
   parameter int DW = 8,
   parameter int BL = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd,
   input  logic               early,
   input  logic               expired,
   input  logic               stb_a,
   input  logic               stb_b,
   input  logic [DW-1:0]      dat_a,
   input  logic [DW-1:0]      dat_b,
   output logic               tmr_start,
   output logic               tmr_run,
   output logic               busy,
   output logic               done,
   output logic               err,
   output logic [BL*DW-1:0]   word
);
   localparam int NP = BL / 2;
   localparam int IW = idx_width(NP);

   rx_state_e        state;
   logic [IW-1:0]    idx;
   logic             prev_b;
   logic             rise, pair_ok, cap, last_pair;
   logic [IW-1:0]    slot;
   logic [BL*DW-1:0] stg, stg_n;

   assign rise      = stb_a && !prev_b;
   assign pair_ok   = rise && !stb_b;
   assign slot      = (state == RX_WAIT) ? '0 : idx;
   assign cap       = ((state == RX_WAIT) && pair_ok && !early) ||
                      ((state == RX_CAPT) && pair_ok);
   assign last_pair = (slot == IW'(NP - 1));

   generate
      for (genvar p = 0; p < NP; p++) begin : g_slot
         assign stg_n[p*2*DW +: 2*DW] = (cap && (slot == IW'(p))) ?
                                        {dat_b, dat_a} : stg[p*2*DW +: 2*DW];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= RX_IDLE;
         idx    <= '0;
         prev_b <= 1'b0;
         stg    <= '0;
         word   <= '0;
         done   <= 1'b0;
         err    <= 1'b0;
      end else begin
         prev_b <= stb_b;
         done   <= 1'b0;
         err    <= 1'b0;
         if (cap) stg <= stg_n;
         case (state)
            RX_IDLE: if (cmd) state <= RX_WAIT;
            RX_WAIT: begin
               if (rise) begin
                  if (early || stb_b) begin
                     err   <= 1'b1;
                     state <= RX_IDLE;
                  end else if (last_pair) begin
                     word  <= stg_n;
                     done  <= 1'b1;
                     state <= RX_IDLE;
                  end else begin
                     idx   <= IW'(1);
                     state <= RX_CAPT;
                  end
               end else if (expired) begin
                  err   <= 1'b1;
                  state <= RX_IDLE;
               end
            end
            RX_CAPT: begin
               if (!pair_ok) begin
                  err   <= 1'b1;
                  state <= RX_IDLE;
               end else if (last_pair) begin
                  word  <= stg_n;
                  done  <= 1'b1;
                  state <= RX_IDLE;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            default: state <= RX_IDLE;
         endcase
      end
   end

   assign tmr_start = cmd && (state == RX_IDLE);
   assign tmr_run   = (state == RX_WAIT);
   assign busy      = (state != RX_IDLE);
endmodule

// File: rtl/ddr_beat_strobe_path.sv
`timescale 1ns/1ps
module ddr_beat_strobe_path #(
   parameter int DW       = 8,
   parameter int BL       = 4,
   parameter int RD_LAT   = 2,
   parameter int RD_SLACK = 1,
   parameter bit TX_SHIFT = 1'b1,
   localparam int MW      = DW / 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tx_start,
   input  logic [BL*DW-1:0]   tx_data,
   input  logic [BL*MW-1:0]   tx_mask,
   output logic               tx_busy,
   output logic               tx_stb_oe,
   output logic               tx_stb_a,
   output logic               tx_stb_b,
   output logic               tx_dat_oe,
   output logic [DW-1:0]      tx_dat_a,
   output logic [DW-1:0]      tx_dat_b,
   output logic [MW-1:0]      tx_msk_a,
   output logic [MW-1:0]      tx_msk_b,
   input  logic               rx_cmd,
   input  logic               rx_stb_a,
   input  logic               rx_stb_b,
   input  logic [DW-1:0]      rx_dat_a,
   input  logic [DW-1:0]      rx_dat_b,
   output logic               rx_busy,
   output logic               rx_done,
   output logic               rx_err,
   output logic [BL*DW-1:0]   rx_word
);
   generate
      if ((DW < 8) || (DW % 8 != 0)) begin : g_bad_dw
         $error("DW must be a non-zero multiple of 8");
      end
      if ((BL < 2) || (BL % 2 != 0)) begin : g_bad_bl
         $error("BL must be even and at least 2");
      end
      if (RD_LAT < 1) begin : g_bad_lat
         $error("RD_LAT must be at least 1");
      end
      if (RD_SLACK < 0) begin : g_bad_slack
         $error("RD_SLACK must not be negative");
      end
   endgenerate

   logic early, expired, tmr_start, tmr_run;

   dbs_tx_path #(.DW(DW), .BL(BL), .MW(MW), .SHIFT(TX_SHIFT)) u_tx (
      .clk(clk), .rst_n(rst_n), .start(tx_start), .data(tx_data), .mask(tx_mask),
      .busy(tx_busy), .stb_oe(tx_stb_oe), .stb_a(tx_stb_a), .stb_b(tx_stb_b),
      .dat_oe(tx_dat_oe), .dat_a(tx_dat_a), .dat_b(tx_dat_b),
      .msk_a(tx_msk_a), .msk_b(tx_msk_b)
   );

   dbs_lat_timer #(.RD_LAT(RD_LAT), .RD_SLACK(RD_SLACK)) u_tmr (
      .clk(clk), .rst_n(rst_n), .start(tmr_start), .run(tmr_run),
      .early(early), .expired(expired)
   );

   dbs_rx_capture #(.DW(DW), .BL(BL)) u_rx (
      .clk(clk), .rst_n(rst_n), .cmd(rx_cmd), .early(early), .expired(expired),
      .stb_a(rx_stb_a), .stb_b(rx_stb_b), .dat_a(rx_dat_a), .dat_b(rx_dat_b),
      .tmr_start(tmr_start), .tmr_run(tmr_run), .busy(rx_busy),
      .done(rx_done), .err(rx_err), .word(rx_word)
   );
endmodule

// File: rtl/dbs_chk.sv
`timescale 1ns/1ps
module dbs_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_busy,
   input logic tx_stb_oe,
   input logic tx_stb_a,
   input logic tx_stb_b,
   input logic tx_dat_oe,
   input logic rx_busy,
   input logic rx_done,
   input logic rx_err
);
   // R5
   stb_quiet_when_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_stb_oe |-> (!tx_stb_a && !tx_stb_b && !tx_busy));

   // R3
   beats_ride_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_dat_oe |-> (tx_stb_oe && tx_stb_a && !tx_stb_b));

   // R2
   preamble_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_stb_oe) |-> (!tx_dat_oe && !tx_stb_a));

   // R5
   postamble_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_dat_oe) |-> (tx_stb_oe && !tx_stb_a) ##1 !tx_stb_oe);

   // R7
   done_err_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_done && rx_err));

   // R7
   done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> !rx_done);

   // R11
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |-> $past(rx_busy));

   // R8
   err_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_err |-> $past(rx_busy));
endmodule

bind ddr_beat_strobe_path dbs_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tx_busy(tx_busy), .tx_stb_oe(tx_stb_oe),
   .tx_stb_a(tx_stb_a), .tx_stb_b(tx_stb_b), .tx_dat_oe(tx_dat_oe),
   .rx_busy(rx_busy), .rx_done(rx_done), .rx_err(rx_err)
);

// File: tb/sim_ddr_beat_strobe_path.sv
`timescale 1ns/1ps
module sim_ddr_beat_strobe_path;
   localparam int DW    = 8;
   localparam int BL    = 4;
   localparam int LAT   = 2;
   localparam int SLACK = 1;
   localparam int MW    = DW / 8;
   localparam int NP    = BL / 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_start = 1'b0;
   logic [BL*DW-1:0] tx_data = '0;
   logic [BL*MW-1:0] tx_mask = '0;
   logic tx_busy, tx_stb_oe, tx_stb_a, tx_stb_b, tx_dat_oe;
   logic [DW-1:0] tx_dat_a, tx_dat_b;
   logic [MW-1:0] tx_msk_a, tx_msk_b;
   logic rx_cmd = 1'b0, rx_stb_a = 1'b0, rx_stb_b = 1'b0;
   logic [DW-1:0] rx_dat_a = '0, rx_dat_b = '0;
   logic rx_busy, rx_done, rx_err;
   logic [BL*DW-1:0] rx_word;

   int checks = 0;
   int errors = 0;
   logic [BL*DW-1:0] last_word = '0;

   always #5 clk = ~clk;

   ddr_beat_strobe_path #(.DW(DW), .BL(BL), .RD_LAT(LAT), .RD_SLACK(SLACK)) u0 (
      .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_data(tx_data), .tx_mask(tx_mask),
      .tx_busy(tx_busy), .tx_stb_oe(tx_stb_oe), .tx_stb_a(tx_stb_a), .tx_stb_b(tx_stb_b),
      .tx_dat_oe(tx_dat_oe), .tx_dat_a(tx_dat_a), .tx_dat_b(tx_dat_b),
      .tx_msk_a(tx_msk_a), .tx_msk_b(tx_msk_b), .rx_cmd(rx_cmd),
      .rx_stb_a(rx_stb_a), .rx_stb_b(rx_stb_b), .rx_dat_a(rx_dat_a), .rx_dat_b(rx_dat_b),
      .rx_busy(rx_busy), .rx_done(rx_done), .rx_err(rx_err), .rx_word(rx_word)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // R2 R3 R4 R5: one transmit burst, every cycle compared; optional retrigger while busy
   task automatic tx_burst(input logic [BL*DW-1:0] d, input logic [BL*MW-1:0] m,
                           input bit retrig);
      tx_data  = d;
      tx_mask  = m;
      tx_start = 1'b1;
      @(negedge clk);
      tx_start = 1'b0;
      tx_data  = ~d;
      tx_mask  = ~m;
      chk("R2", "pre oe/a/b/dat_oe/busy",
          {tx_stb_oe, tx_stb_a, tx_stb_b, tx_dat_oe, tx_busy}, 5'b10001);
      for (int k = 0; k < NP; k++) begin
         if (retrig && k == 0) tx_start = 1'b1;
         @(negedge clk);
         tx_start = 1'b0;
         chk("R3", "pair strobe", {tx_stb_oe, tx_stb_a, tx_stb_b, tx_dat_oe}, 4'b1101);
         chk("R3", "beat even", tx_dat_a, d[(2*k)*DW +: DW]);
         chk("R3", "beat odd",  tx_dat_b, d[(2*k+1)*DW +: DW]);
         chk("R4", "mask even", tx_msk_a, m[(2*k)*MW +: MW]);
         chk("R4", "mask odd",  tx_msk_b, m[(2*k+1)*MW +: MW]);
      end
      @(negedge clk);
      chk("R5", "post oe/a/b/dat_oe",
          {tx_stb_oe, tx_stb_a, tx_stb_b, tx_dat_oe}, 4'b1000);
      chk("R4", "lanes zero in post", {tx_dat_a, tx_dat_b, tx_msk_a, tx_msk_b}, '0);
      @(negedge clk);
      chk("R5", "released oe/busy", {tx_stb_oe, tx_busy}, 2'b00);
   endtask

   // R6..R11: read with pairs from edge st for np pairs; expect done or err at err_edge
   task automatic rx_case(input int st, input int np, input bit exp_done, input int err_edge,
                          input logic [BL*DW-1:0] w, input bit recmd);
      int last_k;
      last_k = exp_done ? st + NP - 1 : err_edge;
      rx_cmd = 1'b1;
      @(negedge clk);
      rx_cmd = 1'b0;
      chk("R11", "busy after cmd", rx_busy, 1'b1);
      for (int k = 1; k <= last_k; k++) begin
         rx_cmd = (recmd && k == 1);
         if (k >= st && k < st + np) begin
            rx_stb_a = 1'b1;
            rx_stb_b = 1'b0;
            rx_dat_a = w[(2*(k-st))*DW +: DW];
            rx_dat_b = w[(2*(k-st)+1)*DW +: DW];
         end else begin
            rx_stb_a = 1'b0;
            rx_stb_b = 1'b0;
            rx_dat_a = 8'hEE;
            rx_dat_b = 8'hDD;
         end
         @(negedge clk);
         rx_cmd = 1'b0;
         if (k == last_k) begin
            if (exp_done) begin
               chk("R7", "done/err", {rx_done, rx_err}, 2'b10);
               chk("R7", "word", rx_word, w);
               chk("R11", "busy low at done", rx_busy, 1'b0);
               last_word = w;
            end else begin
               chk("R8", "err/done", {rx_err, rx_done}, 2'b10);
               chk("R10", "word kept on discard", rx_word, last_word);
            end
         end else begin
            chk("R6", "no early done/err", {rx_done, rx_err}, 2'b00);
         end
      end
      rx_stb_a = 1'b0;
      rx_stb_b = 1'b0;
      @(negedge clk);
      chk("R7", "pulse ends", {rx_done, rx_err, rx_busy}, 3'b000);
      chk("R7", "word held", rx_word, last_word);
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "outputs in reset",
          {tx_busy, tx_stb_oe, tx_stb_a, tx_stb_b, tx_dat_oe, rx_busy, rx_done, rx_err}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "outputs after reset",
          {tx_busy, tx_stb_oe, tx_dat_oe, tx_dat_a, tx_dat_b, rx_busy, rx_done, rx_err}, '0);
      chk("R1", "rx_word after reset", rx_word, '0);

      for (int p = 0; p < 16; p++) begin
         logic [BL*DW-1:0] d;
         d = 32'h01234567 ^ (32'(p) * 32'h1F3C5A97);
         tx_burst(d, 4'(p), 1'b0);
      end
      // R5: retrigger during burst ignored
      tx_burst(32'hA5C3_3C5A, 4'b1010, 1'b1);
      @(negedge clk);
      chk("R5", "no burst after ignored start", {tx_stb_oe, tx_busy}, 2'b00);

      // R6 R7: all allowed arrival offsets, several words
      for (int d = 0; d <= SLACK; d++) begin
         for (int p = 0; p < 4; p++) begin
            rx_case(LAT + d, NP, 1'b1, 0, 32'hC0DE_0000 + 32'(p * 32'h1111 + d), 1'b0);
         end
      end
      // R8: strobe never arrives
      rx_case(100, 0, 1'b0, LAT + SLACK, 32'h0, 1'b0);
      // R9: strobe one clock early
      rx_case(LAT - 1, NP, 1'b0, LAT - 1, 32'h1357_9BDF, 1'b0);
      // R10: strobe stops after first pair
      rx_case(LAT, 1, 1'b0, LAT + 1, 32'h2468_ACE0, 1'b0);
      // R11: second command while busy does not restart the count
      rx_case(LAT, NP, 1'b1, 0, 32'hFACE_B00C, 1'b1);
      rx_case(LAT + SLACK, NP, 1'b1, 0, 32'h0BAD_F00D, 1'b1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule